// File: doc/BRIEF.md
# Processor Bus Command Controller

This block sits beside a processor that announces each bus cycle with a three-bit status code. On every clock it samples the code. When the code leaves the idle value, it runs a short cycle sequence. The sequence produces active-low memory, I/O and interrupt-acknowledge commands, plus the control strobes for address latches and data transceivers:

- an address latch enable pulse;
- a data enable;
- a transmit/receive direction;
- a shared cascade/peripheral data enable.

Write commands come in two timings. The advanced write asserts one clock state earlier than the normal write.

A multi-master system uses three inputs to control when the block may drive the shared command lines:

- **Address enable (active low).** It must have been low for a programmable number of clocks before commands are driven. Releasing it withdraws them at once.
- **Command enable.** It forces every command and both data enables inactive.
- **Mode strap.** When set, I/O-bus mode frees the I/O commands from the address enable.

Output three-state control is modelled as two enable outputs, one for the memory command group and one for the I/O command group.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is held, every command output is HIGH, and address latch enable, data enable and direction are LOW.
- R2: Status decode: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt (no command), 100 and 101 memory read, 110 memory write, 111 passive (no command). Command bit order, bit 0 first: memory read, memory write, advanced memory write, I/O read, I/O write, advanced I/O write, interrupt acknowledge. At most two commands are ever active together.
- R3: Address latch enable is HIGH for exactly one clock: the first clock after the status is sampled non-passive while the block is idle. This includes halt.
- R4: Read-type commands (memory read, I/O read, interrupt acknowledge) go LOW in the second clock of the cycle. They stay LOW until the clock after passive status is sampled.
- R5: The advanced write command goes LOW in the second clock of a write cycle. The normal write goes LOW one clock later.
- R6: Data enable goes HIGH in the third clock of a read-type cycle and in the second clock of a write cycle. It goes LOW together with the commands.
- R7: Direction is HIGH from the first clock to the end of any write cycle, and LOW for read-type, halt and idle.
- R8: Once passive status is sampled in an active cycle, all commands and data enable are inactive from the next clock.
- R9: The memory command enable, and the memory commands, turn on only after the address-enable input has been sampled LOW on AEN_DELAY consecutive clock edges. Until then, the memory commands stay HIGH.
- R10: When address enable goes HIGH, the command enables drop and the gated commands go HIGH in the same clock, with no register in the path.
- R11: In I/O-bus mode (strap HIGH), the I/O command enable is HIGH and the I/O commands and interrupt acknowledge run regardless of address enable. Memory commands remain gated.
- R12: With command enable LOW, all commands are HIGH and data enable and peripheral enable are LOW, in the same clock.
- R13: The peripheral enable output depends on the mode. In system-bus mode it is HIGH during the address latch clock of an interrupt-acknowledge cycle. In I/O-bus mode it follows data enable during I/O and interrupt-acknowledge cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 3 | Processor bus status code |
| addr_en_n_i | input | 1 | Address enable, active low |
| cmd_en_i | input | 1 | Command enable, active high |
| io_bus_mode_i | input | 1 | Mode strap: 1 = I/O-bus mode, 0 = system-bus mode |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| mem_wr_adv_n_o | output | 1 | Advanced memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| io_wr_adv_n_o | output | 1 | Advanced I/O write command, active low |
| int_ack_n_o | output | 1 | Interrupt acknowledge command, active low |
| ale_o | output | 1 | Address latch enable, active high |
| data_en_o | output | 1 | Data transceiver enable, active high |
| dir_tx_o | output | 1 | Data direction: 1 = transmit, 0 = receive |
| periph_en_o | output | 1 | Cascade / peripheral data enable, active high |
| mem_cmd_oe_o | output | 1 | Drive enable of the memory command group |
| io_cmd_oe_o | output | 1 | Drive enable of the I/O command group |

## Verification
The bench builds the block with AEN_DELAY set to 5 rather than the default 3. This lets it walk the address-enable window one clock at a time and check separately the last blocked edge and the first enabled edge. With that longer window, a cycle can also reach its hold state before the window has finished. That exposes the difference between the registered cycle sequence and the gating applied to the commands at the outputs.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    typedef enum logic [2:0] {
        ST_INTA    = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_FETCH   = 3'b100,
        ST_MRD     = 3'b101,
        ST_MWR     = 3'b110,
        ST_PASSIVE = 3'b111
    } bus_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_T1   = 2'd1,
        PH_T2   = 2'd2,
        PH_T3   = 2'd3
    } phase_e;

    localparam int NUM_CMDS = 7;
    localparam int CMD_MRD  = 0;
    localparam int CMD_MWR  = 1;
    localparam int CMD_AMW  = 2;
    localparam int CMD_IORD = 3;
    localparam int CMD_IOWR = 4;
    localparam int CMD_AIOW = 5;
    localparam int CMD_INTA = 6;

    // Commands that belong to the I/O group (exempt from address enable in I/O-bus mode)
    localparam logic [NUM_CMDS-1:0] IO_GROUP = 7'b111_1000;

    typedef struct packed {
        logic rd_mem;
        logic wr_mem;
        logic rd_io;
        logic wr_io;
        logic ack;
    } cyc_kind_t;

    typedef struct packed {
        phase_e     phase;
        logic [2:0] code;
    } fsm_state_t;

endpackage

// File: rtl/bcc_status_decode.sv
module bcc_status_decode
    import bcc_pkg::*;
(
    input  logic [2:0] code_i,
    output cyc_kind_t  kind_o
);

    always_comb begin
        kind_o = '0;
        case (code_i)
            ST_INTA:  kind_o.ack    = 1'b1;
            ST_IORD:  kind_o.rd_io  = 1'b1;
            ST_IOWR:  kind_o.wr_io  = 1'b1;
            ST_FETCH: kind_o.rd_mem = 1'b1;
            ST_MRD:   kind_o.rd_mem = 1'b1;
            ST_MWR:   kind_o.wr_mem = 1'b1;
            default:  kind_o = '0;   // halt and passive carry no command
        endcase
    end

endmodule

// File: rtl/bcc_aen_timer.sv
module bcc_aen_timer #(
    parameter int AEN_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_en_n_i,
    output logic ready_o
);

    localparam int CW = $clog2(AEN_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(AEN_DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (addr_en_n_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == LIMIT);

    // R9: a HIGH address enable restarts the window
    p_timer_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en_n_i |=> !ready_o);

endmodule

// File: rtl/bcc_cycle_fsm.sv
module bcc_cycle_fsm
    import bcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          status_i,
    output logic [NUM_CMDS-1:0] cmd_act_o,
    output logic                den_o,
    output logic                dir_tx_o,
    output logic                ale_o,
    output logic                io_cyc_o,
    output logic                ack_cyc_o
);

    fsm_state_t st_d, st_q;
    cyc_kind_t  kind;
    logic       passive;

    assign passive = (status_i == ST_PASSIVE);

    bcc_status_decode u_decode (
        .code_i (st_q.code),
        .kind_o (kind)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (!passive) begin
                    st_d.phase = PH_T1;
                    st_d.code  = status_i;
                end
            end
            PH_T1:   st_d.phase = passive ? PH_IDLE : PH_T2;
            PH_T2:   st_d.phase = passive ? PH_IDLE : PH_T3;
            default: st_d.phase = passive ? PH_IDLE : PH_T3;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.code  <= ST_PASSIVE;
        end else begin
            st_q <= st_d;
        end
    end

    logic in_cyc, late, hold, is_rd, is_wr;

    always_comb begin
        in_cyc = (st_q.phase != PH_IDLE);
        late   = (st_q.phase == PH_T2) || (st_q.phase == PH_T3);
        hold   = (st_q.phase == PH_T3);
        is_rd  = kind.rd_mem | kind.rd_io | kind.ack;
        is_wr  = kind.wr_mem | kind.wr_io;

        cmd_act_o           = '0;
        cmd_act_o[CMD_MRD]  = kind.rd_mem & late;
        cmd_act_o[CMD_AMW]  = kind.wr_mem & late;
        cmd_act_o[CMD_MWR]  = kind.wr_mem & hold;
        cmd_act_o[CMD_IORD] = kind.rd_io  & late;
        cmd_act_o[CMD_AIOW] = kind.wr_io  & late;
        cmd_act_o[CMD_IOWR] = kind.wr_io  & hold;
        cmd_act_o[CMD_INTA] = kind.ack    & late;

        den_o     = (is_rd & hold) | (is_wr & late);
        dir_tx_o  = is_wr & in_cyc;
        ale_o     = (st_q.phase == PH_T1);
        io_cyc_o  = (kind.rd_io | kind.wr_io | kind.ack) & in_cyc;
        ack_cyc_o = kind.ack & in_cyc;
    end

    // R3: the latch strobe never lasts two clocks
    p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    // R8: passive status ends any active cycle
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && passive) |=> (st_q.phase == PH_IDLE && cmd_act_o == '0 && !den_o));

    // R5: the normal write is always preceded by the advanced write
    p_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act_o[CMD_MWR] || cmd_act_o[CMD_IOWR]) |->
            ($past(cmd_act_o[CMD_AMW]) || $past(cmd_act_o[CMD_AIOW])));

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
    import bcc_pkg::*;
#(
    parameter int AEN_DELAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status_i,
    input  logic       addr_en_n_i,
    input  logic       cmd_en_i,
    input  logic       io_bus_mode_i,
    output logic       mem_rd_n_o,
    output logic       mem_wr_n_o,
    output logic       mem_wr_adv_n_o,
    output logic       io_rd_n_o,
    output logic       io_wr_n_o,
    output logic       io_wr_adv_n_o,
    output logic       int_ack_n_o,
    output logic       ale_o,
    output logic       data_en_o,
    output logic       dir_tx_o,
    output logic       periph_en_o,
    output logic       mem_cmd_oe_o,
    output logic       io_cmd_oe_o
);

    logic [NUM_CMDS-1:0] cmd_act, cmd_n;
    logic den_act, dir_tx, ale, io_cyc, ack_cyc, aen_ready, mem_oe, io_oe;

    bcc_aen_timer #(.AEN_DELAY(AEN_DELAY)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_en_n_i (addr_en_n_i),
        .ready_o     (aen_ready)
    );

    bcc_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_i),
        .cmd_act_o (cmd_act),
        .den_o     (den_act),
        .dir_tx_o  (dir_tx),
        .ale_o     (ale),
        .io_cyc_o  (io_cyc),
        .ack_cyc_o (ack_cyc)
    );

    always_comb begin
        mem_oe = aen_ready & ~addr_en_n_i;
        io_oe  = io_bus_mode_i | mem_oe;
    end

    for (genvar g = 0; g < NUM_CMDS; g++) begin : g_cmd
        if (IO_GROUP[g]) begin : g_io
            assign cmd_n[g] = ~(cmd_act[g] & cmd_en_i & io_oe);
        end else begin : g_mem
            assign cmd_n[g] = ~(cmd_act[g] & cmd_en_i & mem_oe);
        end
    end

    always_comb begin
        mem_rd_n_o     = cmd_n[CMD_MRD];
        mem_wr_n_o     = cmd_n[CMD_MWR];
        mem_wr_adv_n_o = cmd_n[CMD_AMW];
        io_rd_n_o      = cmd_n[CMD_IORD];
        io_wr_n_o      = cmd_n[CMD_IOWR];
        io_wr_adv_n_o  = cmd_n[CMD_AIOW];
        int_ack_n_o    = cmd_n[CMD_INTA];
        ale_o          = ale;
        dir_tx_o       = dir_tx;
        data_en_o      = den_act & cmd_en_i;
        periph_en_o    = cmd_en_i & (io_bus_mode_i ? (den_act & io_cyc) : (ack_cyc & ale));
        mem_cmd_oe_o   = mem_oe;
        io_cmd_oe_o    = io_oe;
    end

    // R12: command enable LOW silences commands and both data enables
    p_cmd_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_en_i |-> (&cmd_n && !data_en_o && !periph_en_o));

    // R10: address enable HIGH in system-bus mode withdraws every command
    p_aen_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_en_n_i && !io_bus_mode_i) |-> (!mem_cmd_oe_o && !io_cmd_oe_o && &cmd_n));

    // R2: never more than an advanced/normal pair active
    p_cmd_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cmd_n) <= 2);

    // R7: any write command implies transmit direction
    p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_adv_n_o || !io_wr_adv_n_o) |-> dir_tx_o);

endmodule

// File: tb/bus_cmd_ctrl_bench.sv
module bus_cmd_ctrl_bench;

    localparam int DLY = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic       aen_n = 1'b0;
    logic       cen = 1'b1;
    logic       iob = 1'b0;

    logic mem_rd_n, mem_wr_n, mem_wr_adv_n, io_rd_n, io_wr_n, io_wr_adv_n, int_ack_n;
    logic ale, data_en, dir_tx, periph_en, mem_oe, io_oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_cmd_ctrl #(.AEN_DELAY(DLY)) u_bus_cmd_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .status_i       (status),
        .addr_en_n_i    (aen_n),
        .cmd_en_i       (cen),
        .io_bus_mode_i  (iob),
        .mem_rd_n_o     (mem_rd_n),
        .mem_wr_n_o     (mem_wr_n),
        .mem_wr_adv_n_o (mem_wr_adv_n),
        .io_rd_n_o      (io_rd_n),
        .io_wr_n_o      (io_wr_n),
        .io_wr_adv_n_o  (io_wr_adv_n),
        .int_ack_n_o    (int_ack_n),
        .ale_o          (ale),
        .data_en_o      (data_en),
        .dir_tx_o       (dir_tx),
        .periph_en_o    (periph_en),
        .mem_cmd_oe_o   (mem_oe),
        .io_cmd_oe_o    (io_oe)
    );

    // bit 0 memory read ... bit 6 interrupt acknowledge
    function automatic logic [6:0] cmds();
        return {int_ack_n, io_wr_adv_n, io_wr_n, io_rd_n, mem_wr_adv_n, mem_wr_n, mem_rd_n};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cmds", 32'(cmds()), 32'h7F);
        chk("R1 ale", 32'(ale), 0);
        chk("R1 den", 32'(data_en), 0);
        chk("R1 dir", 32'(dir_tx), 0);
        rst_n = 1'b1;
        repeat (DLY - 1) @(negedge clk);
        chk("R9 window not yet open", 32'(mem_oe), 0);
        @(negedge clk);
        chk("R9 window open", 32'(mem_oe), 1);
    endtask

    task automatic t_read(logic [2:0] code, int idx, string tag);
        logic [6:0] exp = 7'h7F & ~(7'(1) << idx);
        @(negedge clk) status = code;
        @(negedge clk);
        chk({tag, " R3 ale"}, 32'(ale), 1);
        chk({tag, " R4 no cmd in T1"}, 32'(cmds()), 32'h7F);
        chk({tag, " R7 dir read"}, 32'(dir_tx), 0);
        @(negedge clk);
        chk({tag, " R3 ale one clock"}, 32'(ale), 0);
        chk({tag, " R2 R4 cmd"}, 32'(cmds()), 32'(exp));
        chk({tag, " R6 den late"}, 32'(data_en), 0);
        @(negedge clk);
        chk({tag, " R6 den"}, 32'(data_en), 1);
        chk({tag, " R4 cmd held"}, 32'(cmds()), 32'(exp));
        status = 3'b111;
        @(negedge clk);
        chk({tag, " R8 release"}, 32'(cmds()), 32'h7F);
        chk({tag, " R8 den off"}, 32'(data_en), 0);
    endtask

    task automatic t_write(logic [2:0] code, int nidx, int aidx, string tag);
        logic [6:0] adv  = 7'h7F & ~(7'(1) << aidx);
        logic [6:0] both = adv & ~(7'(1) << nidx);
        @(negedge clk) status = code;
        @(negedge clk);
        chk({tag, " R3 ale"}, 32'(ale), 1);
        chk({tag, " R7 dir tx"}, 32'(dir_tx), 1);
        @(negedge clk);
        chk({tag, " R5 adv only"}, 32'(cmds()), 32'(adv));
        chk({tag, " R6 den write"}, 32'(data_en), 1);
        @(negedge clk);
        chk({tag, " R5 both"}, 32'(cmds()), 32'(both));
        status = 3'b111;
        @(negedge clk);
        chk({tag, " R8 release"}, 32'(cmds()), 32'h7F);
        chk({tag, " R7 dir end"}, 32'(dir_tx), 0);
    endtask

    task automatic t_halt();
        @(negedge clk) status = 3'b011;
        @(negedge clk);
        chk("R3 halt ale", 32'(ale), 1);
        @(negedge clk);
        @(negedge clk);
        chk("R2 halt no cmd", 32'(cmds()), 32'h7F);
        chk("R2 halt no den", 32'(data_en), 0);
        status = 3'b111;
        @(negedge clk);
    endtask

    task automatic t_aen_window();
        @(negedge clk);
        aen_n = 1'b1;
        status = 3'b101;
        #1;
        chk("R10 oe drop", 32'({mem_oe, io_oe}), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 gated in T2", 32'(mem_rd_n), 1);
        @(negedge clk);
        chk("R9 gated in T3", 32'(mem_rd_n), 1);
        chk("R9 den ungated", 32'(data_en), 1);
        aen_n = 1'b0;
        for (int i = 1; i <= DLY; i++) begin
            @(negedge clk);
            chk("R9 window oe", 32'(mem_oe), 32'(i == DLY));
            chk("R9 window cmd", 32'(mem_rd_n), 32'(i != DLY));
        end
        status = 3'b111;
        @(negedge clk);
    endtask

    task automatic t_aen_drop();
        @(negedge clk) status = 3'b101;
        repeat (3) @(negedge clk);
        chk("R10 before drop", 32'(mem_rd_n), 0);
        aen_n = 1'b1;
        #1;
        chk("R10 immediate release", 32'(mem_rd_n), 1);
        chk("R10 immediate oe", 32'(mem_oe), 0);
        aen_n = 1'b0;
        #0.5;
        status = 3'b111;
        @(negedge clk);
    endtask

    task automatic t_io_mode();
        @(negedge clk);
        iob = 1'b1;
        aen_n = 1'b1;
        #1;
        chk("R11 io oe", 32'({io_oe, mem_oe}), 32'b10);
        status = 3'b001;
        @(negedge clk);
        chk("R13 io mode T1", 32'(periph_en), 0);
        @(negedge clk);
        chk("R11 io read runs", 32'(io_rd_n), 0);
        @(negedge clk);
        chk("R13 io mode periph", 32'(periph_en), 1);
        status = 3'b111;
        @(negedge clk) status = 3'b101;
        @(negedge clk);
        @(negedge clk);
        chk("R11 memory still gated", 32'(mem_rd_n), 1);
        status = 3'b111;
        @(negedge clk);
        iob = 1'b0;
        aen_n = 1'b0;
        repeat (DLY + 1) @(negedge clk);
    endtask

    task automatic t_cascade_and_cen();
        @(negedge clk) status = 3'b000;
        @(negedge clk);
        chk("R13 cascade in T1", 32'(periph_en), 1);
        cen = 1'b0;
        #1;
        chk("R12 periph forced", 32'(periph_en), 0);
        cen = 1'b1;
        @(negedge clk);
        chk("R13 cascade T2 off", 32'(periph_en), 0);
        chk("R2 inta", 32'(int_ack_n), 0);
        @(negedge clk);
        cen = 1'b0;
        #1;
        chk("R12 cmds forced", 32'(cmds()), 32'h7F);
        chk("R12 den forced", 32'(data_en), 0);
        cen = 1'b1;
        #1;
        chk("R12 restored", 32'(int_ack_n), 0);
        status = 3'b111;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_read(3'b101, 0, "mem read");
                t_read(3'b100, 0, "fetch");
                t_read(3'b001, 3, "io read");
                t_read(3'b000, 6, "int ack");
                t_write(3'b110, 1, 2, "mem write");
                t_write(3'b010, 4, 5, "io write");
                t_halt();
                t_aen_window();
                t_aen_drop();
                t_io_mode();
                t_cascade_and_cen();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule